// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a set of peripheral lines, a single lowest-tier software request and a group of non-maskable exception lines. It picks the one request that should reach the processor core and presents it as a request flag, a vector address and a tier code. The ordinary lines each carry a programmable two-bit level. The software request always sits at the bottom tier. The exception lines always sit at the top tier and ignore the core's mask. Each request is held in a pending flag until the core acknowledges it.

The block keeps a record of the tiers that are in service. This lets a higher tier preempt a running routine, while a request at the same or a lower tier waits until the routine signals that it has finished. Two fast slots can redirect any single request to a vector address written directly into the slot. All other vectors are formed from a movable table base. A wake output tells system control that an enabled request is pending while the core sleeps.

Configuration uses a write-only port. Addresses 0 to N_SRC-1 hold the level codes. The next five addresses hold fast slot 0 id, fast slot 1 id, fast vector 0, fast vector 1 and the table base.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset there is no pending request, `irq_req` and `wake` are low, every ordinary level is disabled (code 3), the table base is 0 and both fast slots hold the all-ones id, which matches no request.
- R2: Tier codes on `irq_lvl` are LP=1, L0=2, L1=3, L2=4, L3=5. An ordinary level code 0, 1 or 2 maps to L0, L1 or L2. Code 3 means the line is never forwarded, although its pending flag is kept.
- R3: A maskable request (LP, L0, L1 or L2) is forwarded only when its tier code is strictly greater than `core_mask`.
- R4: The exception lines are tier L3 and are forwarded whatever the value of `core_mask`.
- R5: Request ids are: exception line k is id k, the software request is id N_NMI, and ordinary line i is id N_NMI+1+i. The highest eligible tier wins, and among equal tiers the lowest id wins.
- R6: With no fast-slot hit, `irq_vec` equals the table base plus the id times 2^ENTRY_SHIFT.
- R7: When the winning id equals the id held in a fast slot, `irq_vec` is that slot's direct vector. Slot 0 takes precedence over slot 1.
- R8: A pulse on `irq_ack` while `irq_req` is high clears the winner's pending flag and marks the winner's tier as in service.
- R9: A request is forwarded only when its tier is strictly above the highest in-service tier, and this also applies to L3. A pulse on `svc_done` removes the highest in-service tier.
- R10: `wake` is high exactly when `core_sleep` is high and at least one pending request has an enabled tier, regardless of the mask and of the in-service tiers.
- R11: Inputs and configuration writes are registered on a rising edge. `irq_req`, `irq_vec`, `irq_lvl` and `wake` reflect the new state after that edge, without a further register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ord_irq | input | N_SRC | Ordinary request lines, high for one cycle or more |
| lp_swi | input | 1 | Lowest-tier software request |
| nmi_irq | input | N_NMI | Non-maskable exception lines |
| core_mask | input | 3 | Core mask in tier code; maskable tiers at or below it are held back |
| core_sleep | input | 1 | Core is in a wait or stop state |
| irq_ack | input | 1 | Core accepts the presented request |
| svc_done | input | 1 | Core leaves the innermost routine |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration address |
| cfg_wdata | input | ADDR_W | Configuration write data |
| irq_req | output | 1 | A request is presented to the core |
| irq_vec | output | ADDR_W | Vector address of the presented request |
| irq_lvl | output | 3 | Tier code of the presented request |
| wake | output | 1 | Clock-restart notification to system control |

## Verification
The bench sweeps every ordinary line against every level code and every mask value, and predicts forwarding and the vector arithmetically. A design with an off-by-one mask compare would leak requests at the mask's own tier, and one that ignored code 3 would forward disabled lines.

Nested sequences check that an equal tier stays blocked under a running routine, that a higher tier preempts it, and that a completion exposes the waiting request. A second L3 exception must also wait behind the first, even with the mask at its maximum. A controller that tracked only one in-service tier, or that let L3 bypass nesting, would present a request too early.

Fast-slot tests bind both slots to one id and then to an exception line, which exposes a wrong slot precedence or remapping. Moving the table base exposes a vector computed from a stale or unshifted base.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam logic [2:0] TIER_NONE = 3'd0;
    localparam logic [2:0] TIER_LP   = 3'd1;
    localparam logic [2:0] TIER_L0   = 3'd2;
    localparam logic [2:0] TIER_L1   = 3'd3;
    localparam logic [2:0] TIER_L2   = 3'd4;
    localparam logic [2:0] TIER_L3   = 3'd5;
    localparam logic [1:0] LVL_OFF   = 2'd3;

    function automatic logic [2:0] lvl_to_tier(input logic [1:0] code);
        case (code)
            2'd0:    return TIER_L0;
            2'd1:    return TIER_L1;
            2'd2:    return TIER_L2;
            default: return TIER_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pic_arb.sv
module pic_arb #(
    parameter int N_ID  = 14,
    parameter int VID_W = 4
) (
    input  logic [N_ID-1:0][2:0] tier_i,
    input  logic [N_ID-1:0]      elig_i,
    output logic                 win_vld,
    output logic [VID_W-1:0]     win_id,
    output logic [2:0]           win_tier
);
    always_comb begin
        win_vld  = 1'b0;
        win_id   = '0;
        win_tier = 3'd0;
        for (int k = 0; k < N_ID; k++) begin
            if (elig_i[k] && (tier_i[k] > win_tier)) begin
                win_vld  = 1'b1;
                win_id   = VID_W'(k);
                win_tier = tier_i[k];
            end
        end
    end
endmodule

// File: rtl/pic_vec.sv
module pic_vec #(
    parameter int VID_W       = 4,
    parameter int ADDR_W      = 16,
    parameter int ENTRY_SHIFT = 2,
    parameter int N_FAST      = 2
) (
    input  logic [VID_W-1:0]              win_id,
    input  logic [ADDR_W-1:0]             base,
    input  logic [N_FAST-1:0][VID_W-1:0]  slot_id,
    input  logic [N_FAST-1:0][ADDR_W-1:0] slot_vec,
    output logic [ADDR_W-1:0]             vec
);
    logic [N_FAST-1:0] hit;

    for (genvar s = 0; s < N_FAST; s++) begin : g_slot
        assign hit[s] = (slot_id[s] == win_id);
    end

    always_comb begin
        vec = base + (ADDR_W'(win_id) << ENTRY_SHIFT);
        for (int s = N_FAST - 1; s >= 0; s--) begin
            if (hit[s]) vec = slot_vec[s];
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int N_NMI       = 5,
    parameter int ADDR_W      = 16,
    parameter int ENTRY_SHIFT = 2,
    localparam int N_ID       = N_NMI + 1 + N_SRC,
    localparam int VID_W      = $clog2(N_ID + 1),
    localparam int N_FAST     = 2,
    localparam int CFG_AW     = $clog2(N_SRC + 5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  ord_irq,
    input  logic              lp_swi,
    input  logic [N_NMI-1:0]  nmi_irq,
    input  logic [2:0]        core_mask,
    input  logic              core_sleep,
    input  logic              irq_ack,
    input  logic              svc_done,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vec,
    output logic [2:0]        irq_lvl,
    output logic              wake
);
    localparam int A_SLOT0 = N_SRC;
    localparam int A_SLOT1 = N_SRC + 1;
    localparam int A_FV0   = N_SRC + 2;
    localparam int A_FV1   = N_SRC + 3;
    localparam int A_BASE  = N_SRC + 4;

    typedef struct packed {
        logic [N_ID-1:0]              pend;
        logic [4:0]                   svc;
        logic [N_SRC-1:0][1:0]        lvl;
        logic [N_FAST-1:0][VID_W-1:0] slot_id;
        logic [N_FAST-1:0][ADDR_W-1:0] slot_vec;
        logic [ADDR_W-1:0]            base;
    } state_t;

    state_t st_d, st_q;

    logic [N_ID-1:0]       raw_in;
    logic [N_ID-1:0][2:0]  tier_w;
    logic [N_ID-1:0]       elig;
    logic [2:0]            svc_lvl;
    logic                  win_vld;
    logic [VID_W-1:0]      win_id;
    logic [2:0]            win_tier;

    assign raw_in = {ord_irq, lp_swi, nmi_irq};

    for (genvar k = 0; k < N_ID; k++) begin : g_tier
        if (k < N_NMI) begin : g_nmi
            assign tier_w[k] = TIER_L3;
        end else if (k == N_NMI) begin : g_lp
            assign tier_w[k] = TIER_LP;
        end else begin : g_ord
            assign tier_w[k] = lvl_to_tier(st_q.lvl[k-N_NMI-1]);
        end
        assign elig[k] = st_q.pend[k] && (tier_w[k] != TIER_NONE) &&
                         (tier_w[k] > svc_lvl) &&
                         ((tier_w[k] == TIER_L3) || (tier_w[k] > core_mask));
    end

    always_comb begin
        svc_lvl = TIER_NONE;
        for (int t = 0; t < 5; t++) begin
            if (st_q.svc[t]) svc_lvl = 3'(t + 1);
        end
    end

    pic_arb #(.N_ID(N_ID), .VID_W(VID_W)) u_arb (
        .tier_i  (tier_w),
        .elig_i  (elig),
        .win_vld (win_vld),
        .win_id  (win_id),
        .win_tier(win_tier)
    );

    pic_vec #(.VID_W(VID_W), .ADDR_W(ADDR_W), .ENTRY_SHIFT(ENTRY_SHIFT),
              .N_FAST(N_FAST)) u_vec (
        .win_id  (win_id),
        .base    (st_q.base),
        .slot_id (st_q.slot_id),
        .slot_vec(st_q.slot_vec),
        .vec     (irq_vec)
    );

    assign irq_req = win_vld;
    assign irq_lvl = win_tier;

    always_comb begin
        wake = 1'b0;
        for (int k = 0; k < N_ID; k++) begin
            if (st_q.pend[k] && (tier_w[k] != TIER_NONE)) wake = core_sleep;
        end
    end

    always_comb begin
        st_d = st_q;
        if (irq_ack && win_vld) st_d.pend[win_id] = 1'b0;
        st_d.pend = st_d.pend | raw_in;
        if (svc_done && (svc_lvl != TIER_NONE)) st_d.svc[svc_lvl - 3'd1] = 1'b0;
        if (irq_ack && win_vld) st_d.svc[win_tier - 3'd1] = 1'b1;
        if (cfg_we) begin
            if (int'(cfg_addr) < N_SRC)        st_d.lvl[cfg_addr] = cfg_wdata[1:0];
            else if (int'(cfg_addr) == A_SLOT0) st_d.slot_id[0] = cfg_wdata[VID_W-1:0];
            else if (int'(cfg_addr) == A_SLOT1) st_d.slot_id[1] = cfg_wdata[VID_W-1:0];
            else if (int'(cfg_addr) == A_FV0)   st_d.slot_vec[0] = cfg_wdata;
            else if (int'(cfg_addr) == A_FV1)   st_d.slot_vec[1] = cfg_wdata;
            else if (int'(cfg_addr) == A_BASE)  st_d.base = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend     <= '0;
            st_q.svc      <= '0;
            st_q.lvl      <= {N_SRC{LVL_OFF}};
            st_q.slot_id  <= '1;
            st_q.slot_vec <= '0;
            st_q.base     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_lvl != TIER_L3) |-> (irq_lvl > core_mask));

    p_nest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > svc_lvl));

    p_tier_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl >= TIER_LP && irq_lvl <= TIER_L3));

    p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !raw_in[win_id]) |=> !st_q.pend[$past(win_id)]);

    p_ack_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !svc_done) |=> (svc_lvl >= $past(irq_lvl)));

    p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> core_sleep);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    localparam int N_SRC = 8;
    localparam int N_NMI = 5;
    localparam int ORD0  = N_NMI + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ord_irq = '0;
    logic        lp_swi = 1'b0;
    logic [4:0]  nmi_irq = '0;
    logic [2:0]  core_mask = '0;
    logic        core_sleep = 1'b0;
    logic        irq_ack = 1'b0;
    logic        svc_done = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [2:0]  irq_lvl;
    logic        wake;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ord_irq(ord_irq), .lp_swi(lp_swi),
        .nmi_irq(nmi_irq), .core_mask(core_mask), .core_sleep(core_sleep),
        .irq_ack(irq_ack), .svc_done(svc_done), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl), .wake(wake)
    );

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_ord(input int i);
        @(negedge clk); ord_irq[i] = 1'b1;
        @(negedge clk); ord_irq = '0;
    endtask

    task automatic pulse_nmi(input int k);
        @(negedge clk); nmi_irq[k] = 1'b1;
        @(negedge clk); nmi_irq = '0;
    endtask

    task automatic do_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic do_done();
        @(negedge clk); svc_done = 1'b1;
        @(negedge clk); svc_done = 1'b0;
    endtask

    task automatic chk(input string tag, input logic er, input logic [2:0] el,
                       input logic [15:0] ev);
        total++;
        if (irq_req !== er || (er && (irq_lvl !== el || irq_vec !== ev))) begin
            bad++;
            $display("FAIL %s: req=%b lvl=%0d vec=%h expected req=%b lvl=%0d vec=%h",
                     tag, irq_req, irq_lvl, irq_vec, er, el, ev);
        end
    endtask

    task automatic chk_wake(input string tag, input logic ew);
        total++;
        if (wake !== ew) begin
            bad++;
            $display("FAIL %s: wake=%b expected %b", tag, wake, ew);
        end
    endtask

    function automatic logic [15:0] vaddr(input logic [15:0] b, input int id);
        return b + 16'(id * 4);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        core_sleep = 1'b1;
        chk("R1 idle after reset", 1'b0, 3'd0, 16'h0);
        chk_wake("R1 wake low after reset", 1'b0);
        pulse_ord(0);
        chk("R1 level disabled by default", 1'b0, 3'd0, 16'h0);
        chk_wake("R10 disabled pending no wake", 1'b0);
        wr(0, 16'd0);
        // R11: the write lands in the same edge and shows immediately
        chk("R6 R11 base zero no fast slot", 1'b1, 3'd2, vaddr(16'h0, ORD0));
        chk_wake("R10 enabled pending wakes", 1'b1);
        core_sleep = 1'b0;
        @(negedge clk);
        chk_wake("R10 awake core no wake", 1'b0);
        do_ack();
        chk("R8 cleared after ack", 1'b0, 3'd0, 16'h0);
        do_done();
        wr(0, 16'd3);

        // R2 R3 R6 sweep: every line, code, mask
        base = 16'h0100;
        wr(12, base);
        for (int i = 0; i < N_SRC; i++) begin
            for (int c = 0; c < 4; c++) begin
                for (int m = 0; m < 8; m++) begin
                    int t;
                    logic er;
                    t = (c < 3) ? c + 2 : 0;
                    er = (t != 0) && (t > m);
                    wr(i, 16'(c));
                    core_mask = 3'(m);
                    pulse_ord(i);
                    chk($sformatf("R2 R3 sweep src=%0d code=%0d mask=%0d", i, c, m),
                        er, 3'(t), vaddr(base, ORD0 + i));
                    core_mask = 3'd0;
                    wr(i, 16'd0);
                    do_ack();
                    do_done();
                    chk("R8 sweep clean", 1'b0, 3'd0, 16'h0);
                    wr(i, 16'd3);
                end
            end
        end

        // R5 tie at equal tier, lowest id first
        wr(3, 16'd2); wr(5, 16'd2);
        @(negedge clk); ord_irq = 8'b0010_1000;
        @(negedge clk); ord_irq = '0;
        chk("R5 tie lowest id", 1'b1, 3'd4, vaddr(base, ORD0 + 3));
        do_ack();
        chk("R9 equal blocked after tie ack", 1'b0, 3'd0, 16'h0);
        do_done();
        chk("R5 second of tie", 1'b1, 3'd4, vaddr(base, ORD0 + 5));
        do_ack(); do_done();
        wr(3, 16'd3); wr(5, 16'd3);

        // R9 nesting and preemption
        wr(0, 16'd0); wr(1, 16'd1); wr(2, 16'd0);
        pulse_ord(0);
        chk("R9 first L0", 1'b1, 3'd2, vaddr(base, ORD0));
        do_ack();
        pulse_ord(2);
        chk("R9 equal tier blocked", 1'b0, 3'd0, 16'h0);
        pulse_ord(1);
        chk("R9 higher tier preempts", 1'b1, 3'd3, vaddr(base, ORD0 + 1));
        do_ack();
        chk("R9 both in service", 1'b0, 3'd0, 16'h0);
        do_done();
        chk("R9 outer still in service", 1'b0, 3'd0, 16'h0);
        do_done();
        chk("R9 waiting request released", 1'b1, 3'd2, vaddr(base, ORD0 + 2));
        do_ack(); do_done();
        wr(0, 16'd3); wr(1, 16'd3); wr(2, 16'd3);

        // R4 L3 with mask at maximum, and L3 nesting
        core_mask = 3'd7;
        @(negedge clk); nmi_irq = 5'b10100;
        @(negedge clk); nmi_irq = '0;
        chk("R4 L3 through max mask", 1'b1, 3'd5, vaddr(base, 2));
        do_ack();
        chk("R9 L3 waits behind L3", 1'b0, 3'd0, 16'h0);
        do_done();
        chk("R4 second L3", 1'b1, 3'd5, vaddr(base, 4));
        do_ack(); do_done();
        core_mask = 3'd0;

        // LP tier: R3 mask compare and R6 vector
        @(negedge clk); lp_swi = 1'b1; core_mask = 3'd1;
        @(negedge clk); lp_swi = 1'b0;
        chk("R3 LP masked at mask 1", 1'b0, 3'd0, 16'h0);
        core_mask = 3'd0;
        @(negedge clk);
        chk("R3 LP forwarded at mask 0", 1'b1, 3'd1, vaddr(base, N_NMI));
        do_ack(); do_done();

        // R7 fast slots
        wr(2, 16'd1);
        wr(8, 16'(ORD0 + 2)); wr(10, 16'hBEEF);
        wr(9, 16'(ORD0 + 2)); wr(11, 16'h1111);
        pulse_ord(2);
        chk("R7 slot0 precedence", 1'b1, 3'd3, 16'hBEEF);
        wr(8, 16'hFFFF);
        chk("R7 slot1 after slot0 freed", 1'b1, 3'd3, 16'h1111);
        do_ack(); do_done();
        wr(9, 16'd0);
        pulse_nmi(0);
        chk("R7 slot bound to L3 line", 1'b1, 3'd5, 16'h1111);
        do_ack(); do_done();
        wr(9, 16'hFFFF); wr(2, 16'd3);

        // R6 relocation
        wr(12, 16'h4000);
        wr(4, 16'd0);
        pulse_ord(4);
        chk("R6 relocated base", 1'b1, 3'd2, vaddr(16'h4000, ORD0 + 4));
        wr(12, 16'h8A00);
        chk("R6 base moved again", 1'b1, 3'd2, vaddr(16'h8A00, ORD0 + 4));
        do_ack(); do_done();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule